// File: doc/BRIEF.md
# Channel Dump Report Formatter

This block turns a dump request into a text report sent one character at a time. The report covers a default frequency word and every channel word of a 64-entry table. When a request arrives while the block is idle, it reads the default word, then reads channels 0 to 63 in ascending order. Each read is issued one cycle before its data is expected. Each value is converted to decimal in a multicycle shift-and-add-three unit. The block then emits the line for that value over a valid/ready byte interface that feeds a UART transmitter.

The report has a fixed layout. It starts with a line holding only the default value, then has one line per channel that begins with a two-digit channel index and a space. Each line ends with carriage return and line feed, and a single prompt character closes the report. All values are written as nine zero-padded decimal digits in hertz. The transmitter may stall the stream at any time. The busy output stays high from the request until the prompt has been taken, and requests made during that time are dropped.

Top module: `dump_report_fmt`

## Requirements
- R1: After reset, busy_o, tx_valid_o and rd_en_o are all low.
- R2: A start_i high while busy_o is low sets busy_o in the next cycle. The block then makes exactly 65 reads, each a one-cycle rd_en_o pulse. The first read has rd_dflt_o=1, and the reads after it have rd_dflt_o=0 with rd_idx_o equal to 0, 1, ... 63. rd_data_i is sampled one cycle after each pulse. rd_en_o and tx_valid_o are never high together.
- R3: The first line is the nine decimal digits of the default value, most significant first, each sent as 0x30 plus the digit, followed by 0x0D then 0x0A.
- R4: For channel n, the line is the two decimal digits of n (tens first, zero-padded, ASCII), then 0x20, then the nine value digits as in R3, then 0x0D 0x0A. Channel lines follow the default line in ascending n.
- R5: After the line for channel 63, exactly one 0x2A is sent. tx_valid_o then stays low until the next request, so a report is exactly 908 characters.
- R6: busy_o stays high until the cycle in which the 0x2A is accepted, and it is low in the cycle after.
- R7: start_i while busy_o is high has no effect: the report is neither restarted nor extended. This includes start_i in the very cycle the 0x2A is accepted.
- R8: While tx_valid_o is high and tx_ready_i is low, tx_valid_o stays high and tx_data_o holds its value in the next cycle. Each character is transferred exactly once, in order, under any stall pattern.
- R9: A value of 10^9 or more is printed as its value modulo 10^9 (for example, 1073741823 prints as 073741823).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Dump request, taken only while idle |
| busy_o | output | 1 | High while a report is in progress |
| rd_en_o | output | 1 | Word read strobe toward storage |
| rd_dflt_o | output | 1 | Read selects the default word |
| rd_idx_o | output | 6 | Channel index of the read |
| rd_data_i | input | 30 | Read word, valid one cycle after rd_en_o |
| tx_valid_o | output | 1 | Character available |
| tx_data_o | output | 8 | ASCII character |
| tx_ready_i | input | 1 | Transmitter takes the character |

## Verification
Two events can fall in the same cycle: acceptance of the closing prompt, which ends busy, and a new request on start_i. The bench holds start_i high across the end of a report. It then checks that busy_o goes low for exactly one cycle and then rises again, and that the held request yields one complete second report rather than a restarted or merged first one. Requests pulsed in the middle of a report are judged by comparing the whole character stream against a model built from the stored values. That stream is also compared under constant, random and one-in-four ready patterns.

// File: rtl/dump_pkg.sv
package dump_pkg;
  localparam logic [7:0] CH_ZERO  = 8'h30;
  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_STAR  = 8'h2A;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_LAT,
    S_CONV,
    S_EMIT,
    S_PROMPT
  } state_e;
endpackage

// File: rtl/dump_bin2bcd.sv
module dump_bin2bcd #(
  parameter int VAL_W      = 30,
  parameter int BCD_DIGITS = 10,
  parameter int OUT_DIGITS = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [VAL_W-1:0]        bin_i,
  output logic                    done_o,
  output logic [OUT_DIGITS*4-1:0] bcd_o
);
  localparam int BCD_W  = BCD_DIGITS * 4;
  localparam int WORK_W = BCD_W + VAL_W;
  localparam int CNT_W  = $clog2(VAL_W + 1);

  logic [WORK_W-1:0] work_q;
  logic [BCD_W-1:0]  bcd_adj;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;

  // add 3 to every digit of 5 or more before the shift
  for (genvar g = 0; g < BCD_DIGITS; g++) begin : g_adj
    logic [3:0] dig;
    assign dig = work_q[VAL_W + g*4 +: 4];
    assign bcd_adj[g*4 +: 4] = (dig >= 4'd5) ? dig + 4'd3 : dig;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      work_q <= {{BCD_W{1'b0}}, bin_i};
      cnt_q  <= CNT_W'(VAL_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      work_q <= {bcd_adj, work_q[VAL_W-1:0]} << 1;
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CNT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign bcd_o  = work_q[VAL_W +: OUT_DIGITS*4];
endmodule

// File: rtl/dump_idx_bcd.sv
module dump_idx_bcd #(
  parameter int IDX_DIGITS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    inc_i,
  output logic [IDX_DIGITS*4-1:0] bcd_o
);
  logic [IDX_DIGITS-1:0] cin;

  for (genvar g = 0; g < IDX_DIGITS; g++) begin : g_dig
    logic [3:0] dig_q;
    if (g == 0) begin : g_lsd
      assign cin[g] = inc_i;
    end else begin : g_upper
      assign cin[g] = cin[g-1] & (g_dig[g-1].dig_q == 4'd9);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               dig_q <= '0;
      else if (clear_i)          dig_q <= '0;
      else if (cin[g])           dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
    end

    assign bcd_o[g*4 +: 4] = dig_q;
  end
endmodule

// File: rtl/dump_char_sel.sv
module dump_char_sel
  import dump_pkg::*;
#(
  parameter int DIGITS     = 9,
  parameter int IDX_DIGITS = 2,
  parameter int POS_W      = 4
) (
  input  logic                    dflt_i,
  input  logic [POS_W-1:0]        pos_i,
  input  logic [DIGITS*4-1:0]     val_bcd_i,
  input  logic [IDX_DIGITS*4-1:0] idx_bcd_i,
  output logic [7:0]              char_o,
  output logic                    last_o
);
  localparam int HDR = IDX_DIGITS + 1;

  logic [POS_W-1:0] off;
  logic [POS_W-1:0] rel;
  logic [3:0]       idx_nib;
  logic [3:0]       val_nib;

  assign off = dflt_i ? '0 : POS_W'(HDR);
  assign rel = pos_i - off;

  always_comb begin
    idx_nib = '0;
    for (int i = 0; i < IDX_DIGITS; i++)
      if (pos_i == POS_W'(IDX_DIGITS - 1 - i)) idx_nib = idx_bcd_i[i*4 +: 4];
    val_nib = '0;
    for (int i = 0; i < DIGITS; i++)
      if (rel == POS_W'(DIGITS - 1 - i)) val_nib = val_bcd_i[i*4 +: 4];
  end

  always_comb begin
    last_o = 1'b0;
    if (pos_i < off) begin
      char_o = (pos_i == POS_W'(IDX_DIGITS)) ? CH_SPACE : (CH_ZERO | {4'b0, idx_nib});
    end else if (rel < POS_W'(DIGITS)) begin
      char_o = CH_ZERO | {4'b0, val_nib};
    end else if (rel == POS_W'(DIGITS)) begin
      char_o = CH_CR;
    end else begin
      char_o = CH_LF;
      last_o = 1'b1;
    end
  end
endmodule

// File: rtl/dump_report_fmt.sv
module dump_report_fmt
  import dump_pkg::*;
#(
  parameter int VAL_W      = 30,
  parameter int DIGITS     = 9,
  parameter int CH_NUM     = 64,
  parameter int IDX_DIGITS = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      rd_en_o,
  output logic                      rd_dflt_o,
  output logic [$clog2(CH_NUM)-1:0] rd_idx_o,
  input  logic [VAL_W-1:0]          rd_data_i,
  output logic                      tx_valid_o,
  output logic [7:0]                tx_data_o,
  input  logic                      tx_ready_i
);
  localparam int CH_W       = $clog2(CH_NUM);
  localparam int BCD_DIGITS = (VAL_W * 302 + 999) / 1000;
  localparam int LINE_MAX   = IDX_DIGITS + 1 + DIGITS + 2;
  localparam int POS_W      = $clog2(LINE_MAX + 1);

  state_e                  state_q;
  logic [POS_W-1:0]        pos_q;
  logic                    dflt_q;
  logic [CH_W-1:0]         ch_q;
  logic                    conv_done;
  logic [DIGITS*4-1:0]     val_bcd;
  logic [IDX_DIGITS*4-1:0] idx_bcd;
  logic [7:0]              line_char;
  logic                    line_last;
  logic                    line_end;

  assign line_end = (state_q == S_EMIT) && tx_ready_i && line_last;

  dump_bin2bcd #(
    .VAL_W(VAL_W), .BCD_DIGITS(BCD_DIGITS), .OUT_DIGITS(DIGITS)
  ) u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state_q == S_LAT),
    .bin_i  (rd_data_i),
    .done_o (conv_done),
    .bcd_o  (val_bcd)
  );

  dump_idx_bcd #(.IDX_DIGITS(IDX_DIGITS)) u_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i((state_q == S_IDLE) && start_i),
    .inc_i  (line_end && !dflt_q),
    .bcd_o  (idx_bcd)
  );

  dump_char_sel #(
    .DIGITS(DIGITS), .IDX_DIGITS(IDX_DIGITS), .POS_W(POS_W)
  ) u_sel (
    .dflt_i   (dflt_q),
    .pos_i    (pos_q),
    .val_bcd_i(val_bcd),
    .idx_bcd_i(idx_bcd),
    .char_o   (line_char),
    .last_o   (line_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      dflt_q  <= 1'b1;
      ch_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_RD;
          dflt_q  <= 1'b1;
          ch_q    <= '0;
        end
        S_RD:   state_q <= S_LAT;
        S_LAT:  state_q <= S_CONV;
        S_CONV: if (conv_done) begin
          state_q <= S_EMIT;
          pos_q   <= '0;
        end
        S_EMIT: if (tx_ready_i) begin
          if (line_last) begin
            pos_q <= '0;
            if (dflt_q) begin
              dflt_q  <= 1'b0;
              state_q <= S_RD;
            end else if (ch_q == CH_W'(CH_NUM - 1)) begin
              state_q <= S_PROMPT;
            end else begin
              ch_q    <= ch_q + 1'b1;
              state_q <= S_RD;
            end
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        S_PROMPT: if (tx_ready_i) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign rd_en_o    = (state_q == S_RD);
  assign rd_dflt_o  = dflt_q;
  assign rd_idx_o   = ch_q;
  assign tx_valid_o = (state_q == S_EMIT) || (state_q == S_PROMPT);
  assign tx_data_o  = (state_q == S_PROMPT) ? CH_STAR : line_char;
endmodule

// File: rtl/dump_report_fmt_chk.sv
module dump_report_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       rd_en_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i
);
  logic prompt_acc;
  assign prompt_acc = tx_valid_o && tx_ready_i && (tx_data_o == 8'h2A);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!tx_valid_o && !rd_en_o));

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r2_rd_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o && tx_valid_o));

  a_r3_char_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> ((tx_data_o >= 8'h30 && tx_data_o <= 8'h39) || tx_data_o == 8'h20 ||
                    tx_data_o == 8'h0D || tx_data_o == 8'h0A || tx_data_o == 8'h2A));

  a_r6_prompt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prompt_acc |=> !busy_o);

  a_r7_busy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !prompt_acc) |=> busy_o);

  a_r8_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
endmodule

bind dump_report_fmt dump_report_fmt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .rd_en_o   (rd_en_o),
  .tx_valid_o(tx_valid_o),
  .tx_data_o (tx_data_o),
  .tx_ready_i(tx_ready_i)
);

// File: tb/tb_dump_report_fmt.sv
module tb_dump_report_fmt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        busy;
  logic        rd_en;
  logic        rd_dflt;
  logic [5:0]  rd_idx;
  logic [29:0] rd_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  logic [29:0] mem [65];
  logic [7:0]  exp_q [$];
  int          n_chk = 0;
  int          n_err = 0;
  int          rd_cnt = 0;
  int          prompts = 0;
  int          mode = 0;
  int          cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          pend_busy = 0;
  bit          prev_stall = 0;
  logic [7:0]  prev_data = '0;
  bit          reported = 0;

  always #5 clk = ~clk;

  dump_report_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy),
    .rd_en_o(rd_en), .rd_dflt_o(rd_dflt), .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  // storage model: one cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= rd_dflt ? mem[64] : mem[rd_idx];

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic push_val(logic [29:0] w);
    longint v = longint'(w) % 64'd1000000000;
    longint p = 100000000;
    for (int i = 0; i < 9; i++) begin
      exp_q.push_back(8'(48 + (v / p) % 10));
      p = p / 10;
    end
  endtask

  task automatic push_dump();
    push_val(mem[64]);
    exp_q.push_back(8'h0D); exp_q.push_back(8'h0A);
    for (int k = 0; k < 64; k++) begin
      exp_q.push_back(8'(48 + k / 10));
      exp_q.push_back(8'(48 + k % 10));
      exp_q.push_back(8'h20);
      push_val(mem[k]);
      exp_q.push_back(8'h0D); exp_q.push_back(8'h0A);
    end
    exp_q.push_back(8'h2A);
  endtask

  // transmitter sink and read monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      case (mode)
        0: tx_ready = 1'b1;
        1: begin lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; tx_ready = lfsr[0]; end
        default: tx_ready = (cyc % 4 == 0);
      endcase
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check(tx_valid == 1'b1, "R8", "valid dropped during stall", tx_valid, 1);
          check(tx_data == prev_data, "R8", "data changed during stall", tx_data, prev_data);
        end
        if (pend_busy) begin
          check(busy == 1'b0, "R6", "busy after prompt accepted", busy, 0);
          pend_busy = 0;
        end
        if (rd_en) begin
          check(!tx_valid, "R2", "read overlaps tx", tx_valid, 0);
          if (rd_cnt == 0) check(rd_dflt == 1'b1, "R2", "first read not default", rd_dflt, 1);
          else begin
            check(rd_dflt == 1'b0, "R2", "channel read flagged default", rd_dflt, 0);
            check(int'(rd_idx) == rd_cnt - 1, "R2", "read index order", rd_idx, rd_cnt - 1);
          end
          rd_cnt++;
        end
        if (tx_valid && tx_ready) begin
          if (exp_q.size() == 0) check(0, "R5", "unexpected extra char", tx_data, 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(tx_data == e, "R3/R4", "stream char", tx_data, e);
          end
          if (tx_data == 8'h2A) begin
            check(rd_cnt == 65, "R2", "read count per report", rd_cnt, 65);
            rd_cnt = 0;
            pend_busy = 1;
            prompts++;
          end
        end
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
      end
    end
  end

  task automatic start_pulse();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #2 check(busy == 1'b1, "R2", "busy after start", busy, 1);
  endtask

  task automatic wait_done();
    do begin @(negedge clk); #2; end while (!(exp_q.size() == 0 && !busy));
    check(exp_q.size() == 0, "R5", "chars missing", exp_q.size(), 0);
    repeat (5) begin
      @(negedge clk); #2;
      check(!tx_valid, "R5", "tx after prompt", tx_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(!busy, "R1", "busy in reset", busy, 0);
    check(!tx_valid, "R1", "tx_valid in reset", tx_valid, 0);
    check(!rd_en, "R1", "rd_en in reset", rd_en, 0);
    @(negedge clk); rst_n = 1'b1;

    // full rate, mid-report start ignored (R7)
    mode = 0;
    for (int i = 0; i < 64; i++) mem[i] = 30'((longint'(i) * 15485863 + 7) % 1000000000);
    mem[64] = 30'd123456789;
    push_dump();
    start_pulse();
    repeat (400) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    #2 check(busy, "R7", "busy after ignored start", busy, 1);
    wait_done();

    // boundary values, random stalls (R9, R8)
    mode = 1;
    for (int i = 0; i < 64; i++) mem[i] = 30'(i * i * 1001);
    mem[64] = 30'd0;
    mem[0]  = 30'd999999999;
    mem[1]  = 30'h3FFFFFFF;
    mem[2]  = 30'd1;
    mem[3]  = 30'd100000000;
    mem[63] = 30'd1000000000;
    push_dump();
    start_pulse();
    wait_done();

    // start held across prompt acceptance: one-cycle gap then new report (R6, R7)
    mode = 2;
    push_dump();
    push_dump();
    begin
      int p0;
      p0 = prompts;
      @(negedge clk); start = 1'b1;
      do begin @(negedge clk); #2; end while (prompts == p0);
      @(negedge clk); #2;
      check(!busy, "R6", "gap after prompt", busy, 0);
      @(negedge clk); #2;
      check(busy, "R7", "held start restarts once", busy, 1);
      start = 1'b0;
    end
    wait_done();
    report();
  end
endmodule